// File: doc/BRIEF.md
# Paged scatter-gather DMA channel engine

This block moves bursts between devices and system memory for a small set of DMA channels. Each channel has three registers: a flags word, a byte count and a logical start address. A device asks for a burst by giving a channel, a direction and a byte length. The engine first checks that the channel is enabled and that the direction matches the channel setup. It then limits the length to the channel's remaining count. After that it walks a page translation table held in memory.

Pages are 4096 bytes. Before each page's worth of data, the engine fetches a table entry of 8 bytes. The first 32-bit word of the entry is the physical frame address. The second word is not used. The table starts at a programmable base, and a programmable limit bounds its length. Data moves in 32-bit beats. Each beat is either read from memory and handed to the device, or taken from the device and written to memory. Lengths, counts and addresses are whole words, so their two low bits are zero.

The memory port, the device input stream and the device output stream are valid/ready. A sender raises valid and keeps valid and its payload unchanged until the cycle in which ready is high. The engine stalls without losing data for any pattern of ready from memory or from the device. Memory read data comes back on a separate return-valid strobe. Only one read is outstanding at a time, and the engine always takes the returned data.

Top module: `sgdma_engine`

## Requirements
- R1: After reset, every channel register, the table base, the table limit and the error source register read as zero. `busy` is low and `chan_err` is all zero.
- R2: The register map uses 32-bit words on `reg_addr`. Table base is at 0x008 and table limit is at 0x00C. The error source register is at 0x010; bit n belongs to channel n, and writing 1 to a bit clears it. Channel n's flags word is at 0x100+0x20·n, its count is 8 bytes higher and its address is 16 bytes higher. Flag bits are: bit 0 enable, bit 1 direction (1 = memory to device), bit 8 transfer done, bit 9 setup error, bit 10 address error. All other flag bits read as zero.
- R3: Accepting a request clears bits 8, 9 and 10 of that channel's flags before anything else happens to them.
- R4: A request is rejected if the channel is disabled or if `req_to_dev` differs from flag bit 1. On rejection the engine sets flag bit 9, sets error source bit n (shown on `chan_err[n]`), makes no memory access and leaves the count unchanged.
- R5: An accepted request moves at most the lesser of `req_len` and the count. When it ends, flag bit 8 is set and the count drops by that clamped length. A clamped length of zero ends at once with no memory traffic.
- R6: For logical address A, the table entry is read at (base + 8·(A>>12)) with bit 31 forced to 0. The physical address is frame + A[11:0].
- R7: A transfer is split at every 4096-byte logical page boundary. Each piece starts with its own table-entry fetch.
- R8: If A>>12 is at least limit/8 before a piece starts, the walk stops there. The count is still reduced by the clamped length, and flag bit 8 is set.
- R9: For memory-to-device transfers, each word read from memory is presented on `dout_data` in order. `dout_valid` and `dout_data` hold until `dout_ready`.
- R10: For device-to-memory transfers, each word accepted on `din` is written to memory in order, at consecutive physical addresses.
- R11: While `mem_valid` is high and `mem_ready` is low, the address, the write enable and the write data stay stable. At most one of `mem_valid`, `din_ready` and `dout_valid` is high in any cycle.
- R12: `busy` is high from the cycle after an accepted, non-rejected request until the walk ends. `req_ready` is low whenever `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| req_valid | input | 1 | Device burst request valid |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_ch | input | CHW | Requesting channel |
| req_to_dev | input | 1 | 1 = memory to device, 0 = device to memory |
| req_len | input | 32 | Requested length in bytes |
| busy | output | 1 | Walk in progress |
| mem_valid | output | 1 | Memory access valid |
| mem_ready | input | 1 | Memory accepts access |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| din_valid | input | 1 | Device data word valid |
| din_ready | output | 1 | Engine takes device data word |
| din_data | input | 32 | Device data word |
| dout_valid | output | 1 | Data word for device valid |
| dout_ready | input | 1 | Device takes data word |
| dout_data | output | 32 | Data word for device |
| chan_err | output | NUM_CH | Per-channel error source bits |

## Verification
The bench tries a memory-to-device burst that starts 8 bytes before a page end, with stalls on both memory and the device. This shows whether the split and the second table fetch happen at the right place, and whether back-pressure loses or repeats words. A device-to-memory burst longer than the count separates clamping from plain copying. Another burst with a one-entry table limit shows whether the walk stops early while the count is still charged. A disabled channel and a wrong-direction request are both tried against an enabled channel, to tell rejection apart from success. A table base with bit 31 set and a zero count exercise the address masking and the empty-transfer corners.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_FETCH, S_FWAIT, S_RD, S_RWAIT, S_DOUT, S_DIN, S_WR, S_DONE
  } walk_st_t;

  localparam int FL_EN    = 0;
  localparam int FL_TODEV = 1;
  localparam int FL_TC    = 8;
  localparam int FL_MERR  = 9;
  localparam int FL_AERR  = 10;
  localparam logic [31:0] FLAG_MASK = 32'h0000_0703;

  localparam logic [9:0] A_BASE  = 10'h008;
  localparam logic [9:0] A_LIMIT = 10'h00C;
  localparam logic [9:0] A_ERR   = 10'h010;
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs #(
  parameter int NUM_CH = 4,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [9:0]               addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  input  logic [CHW-1:0]           ev_ch,
  input  logic                     ev_start,
  input  logic                     ev_reject,
  input  logic                     ev_done,
  input  logic [31:0]              ev_len,
  output logic [NUM_CH-1:0]        en_o,
  output logic [NUM_CH-1:0]        todev_o,
  output logic [NUM_CH-1:0][31:0]  cnt_o,
  output logic [NUM_CH-1:0][31:0]  laddr_o,
  output logic [31:0]              base_o,
  output logic [28:0]              lim_ent_o,
  output logic [NUM_CH-1:0]        err_o
);
  import sgdma_pkg::*;

  logic [NUM_CH-1:0][31:0] flags_q;
  logic [31:0]             limit_q;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam logic [9:0] CH_OFS = 10'h100 + 10'(n * 32);
    logic hit_fl, hit_ct, hit_ad, mine;
    assign hit_fl = wr_en && (addr == CH_OFS);
    assign hit_ct = wr_en && (addr == CH_OFS + 10'h008);
    assign hit_ad = wr_en && (addr == CH_OFS + 10'h010);
    assign mine   = (ev_ch == CHW'(n));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags_q[n] <= '0;
        cnt_o[n]   <= '0;
        laddr_o[n] <= '0;
      end else begin
        if (hit_fl) flags_q[n] <= wdata & FLAG_MASK;
        if (hit_ct) cnt_o[n]   <= {wdata[31:2], 2'b00};
        if (hit_ad) laddr_o[n] <= {wdata[31:2], 2'b00};
        if (mine) begin
          if (ev_start)  flags_q[n][FL_AERR:FL_TC] <= 3'b000;
          if (ev_reject) flags_q[n][FL_MERR] <= 1'b1;
          if (ev_done) begin
            flags_q[n][FL_TC] <= 1'b1;
            cnt_o[n]          <= cnt_o[n] - ev_len;
          end
        end
      end
    end

    assign en_o[n]    = flags_q[n][FL_EN];
    assign todev_o[n] = flags_q[n][FL_TODEV];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        err_o[n] <= 1'b0;
      end else if (ev_reject && mine) begin
        err_o[n] <= 1'b1;
      end else if (wr_en && addr == A_ERR && wdata[n]) begin
        err_o[n] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o  <= '0;
      limit_q <= '0;
    end else if (wr_en) begin
      if (addr == A_BASE)  base_o  <= wdata;
      if (addr == A_LIMIT) limit_q <= wdata;
    end
  end
  assign lim_ent_o = limit_q[31:3];

  always_comb begin
    rdata = '0;
    if (addr == A_BASE)  rdata = base_o;
    if (addr == A_LIMIT) rdata = limit_q;
    if (addr == A_ERR)   rdata = 32'(err_o);
    for (int n = 0; n < NUM_CH; n++) begin
      if (addr == 10'h100 + 10'(n * 32))          rdata = flags_q[n];
      if (addr == 10'h100 + 10'(n * 32) + 10'h008) rdata = cnt_o[n];
      if (addr == 10'h100 + 10'(n * 32) + 10'h010) rdata = laddr_o[n];
    end
  end

  p_reject_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> err_o[$past(ev_ch)] && flags_q[$past(ev_ch)][FL_MERR]);

  p_done_sets_tc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> flags_q[$past(ev_ch)][FL_TC]);
endmodule

// File: rtl/sgdma_walk.sv
module sgdma_walk #(
  parameter int NUM_CH = 4,
  parameter int PAGE_W = 12,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [CHW-1:0]           req_ch,
  input  logic                     req_to_dev,
  input  logic [31:0]              req_len,
  input  logic [NUM_CH-1:0]        en_i,
  input  logic [NUM_CH-1:0]        todev_i,
  input  logic [NUM_CH-1:0][31:0]  cnt_i,
  input  logic [NUM_CH-1:0][31:0]  laddr_i,
  input  logic [31:0]              base_i,
  input  logic [28:0]              lim_ent_i,
  output logic [CHW-1:0]           ev_ch,
  output logic                     ev_start,
  output logic                     ev_reject,
  output logic                     ev_done,
  output logic [31:0]              ev_len,
  output logic                     busy,
  output logic                     mem_valid,
  input  logic                     mem_ready,
  output logic                     mem_we,
  output logic [31:0]              mem_addr,
  output logic [31:0]              mem_wdata,
  input  logic                     mem_rvalid,
  input  logic [31:0]              mem_rdata,
  input  logic                     din_valid,
  output logic                     din_ready,
  input  logic [31:0]              din_data,
  output logic                     dout_valid,
  input  logic                     dout_ready,
  output logic [31:0]              dout_data
);
  import sgdma_pkg::*;

  localparam int IDX_W = 32 - PAGE_W;
  localparam logic [PAGE_W:0] PAGE_BYTES = (PAGE_W + 1)'(1) << PAGE_W;

  walk_st_t          st;
  logic [CHW-1:0]    ch_q;
  logic              to_dev_q;
  logic [31:0]       len_q, rem_q, la_q, pa_q, dbuf_q;
  logic [PAGE_W:0]   chunk_q;

  logic              setup_ok;
  logic [31:0]       clamp;
  logic [IDX_W-1:0]  idx;
  logic [PAGE_W:0]   page_left;
  logic              beat_done;
  walk_st_t          beat_st;

  assign setup_ok  = en_i[req_ch] && (todev_i[req_ch] == req_to_dev);
  assign clamp     = (req_len < cnt_i[req_ch]) ? {req_len[31:2], 2'b00} : cnt_i[req_ch];
  assign idx       = la_q[31:PAGE_W];
  assign page_left = PAGE_BYTES - {1'b0, la_q[PAGE_W-1:0]};
  assign beat_done = (st == S_DOUT && dout_ready) || (st == S_WR && mem_ready);
  assign beat_st   = to_dev_q ? S_RD : S_DIN;

  assign req_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign ev_start  = (st == S_IDLE) && req_valid;
  assign ev_reject = ev_start && !setup_ok;
  assign ev_done   = (st == S_DONE);
  assign ev_ch     = (st == S_IDLE) ? req_ch : ch_q;
  assign ev_len    = len_q;

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = pa_q;
    mem_wdata = dbuf_q;
    case (st)
      S_FETCH: begin
        mem_valid = 1'b1;
        mem_addr  = (base_i + (32'(idx) << 3)) & 32'h7FFF_FFFF;
      end
      S_RD: mem_valid = 1'b1;
      S_WR: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
      end
      default: ;
    endcase
  end

  assign din_ready  = (st == S_DIN);
  assign dout_valid = (st == S_DOUT);
  assign dout_data  = dbuf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ch_q     <= '0;
      to_dev_q <= 1'b0;
      len_q    <= '0;
      rem_q    <= '0;
      la_q     <= '0;
      pa_q     <= '0;
      dbuf_q   <= '0;
      chunk_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          ch_q     <= req_ch;
          to_dev_q <= req_to_dev;
          len_q    <= setup_ok ? clamp : 32'd0;
          rem_q    <= clamp;
          la_q     <= laddr_i[req_ch];
          if (setup_ok) st <= (clamp == 32'd0) ? S_DONE : S_CHECK;
        end
        S_CHECK: st <= (29'(idx) >= lim_ent_i) ? S_DONE : S_FETCH;
        S_FETCH: if (mem_ready) st <= S_FWAIT;
        S_FWAIT: if (mem_rvalid) begin
          pa_q    <= mem_rdata + 32'(la_q[PAGE_W-1:0]);
          chunk_q <= (rem_q < 32'(page_left)) ? rem_q[PAGE_W:0] : page_left;
          st      <= beat_st;
        end
        S_RD:    if (mem_ready) st <= S_RWAIT;
        S_RWAIT: if (mem_rvalid) begin
          dbuf_q <= mem_rdata;
          st     <= S_DOUT;
        end
        S_DIN:   if (din_valid) begin
          dbuf_q <= din_data;
          st     <= S_WR;
        end
        S_DONE:  st <= S_IDLE;
        default: ;
      endcase
      if (beat_done) begin
        la_q    <= la_q + 32'd4;
        pa_q    <= pa_q + 32'd4;
        rem_q   <= rem_q - 32'd4;
        chunk_q <= chunk_q - (PAGE_W + 1)'(4);
        if (rem_q == 32'd4)                    st <= S_DONE;
        else if (chunk_q == (PAGE_W + 1)'(4))  st <= S_CHECK;
        else                                   st <= beat_st;
      end
    end
  end

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_one_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_valid, din_ready, dout_valid}));

  p_dout_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid && !dout_ready |=> dout_valid && $stable(dout_data));

  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start && !ev_reject && (clamp != 32'd0) |=> busy);
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine #(
  parameter int NUM_CH = 4,
  parameter int PAGE_W = 12,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [9:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CHW-1:0]    req_ch,
  input  logic              req_to_dev,
  input  logic [31:0]       req_len,
  output logic              busy,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [31:0]       din_data,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [31:0]       dout_data,
  output logic [NUM_CH-1:0] chan_err
);
  logic [CHW-1:0]          ev_ch;
  logic                    ev_start, ev_reject, ev_done;
  logic [31:0]             ev_len;
  logic [NUM_CH-1:0]       en, todev;
  logic [NUM_CH-1:0][31:0] cnt, laddr;
  logic [31:0]             base;
  logic [28:0]             lim_ent;

  sgdma_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .ev_ch(ev_ch), .ev_start(ev_start), .ev_reject(ev_reject),
    .ev_done(ev_done), .ev_len(ev_len),
    .en_o(en), .todev_o(todev), .cnt_o(cnt), .laddr_o(laddr),
    .base_o(base), .lim_ent_o(lim_ent), .err_o(chan_err)
  );

  sgdma_walk #(.NUM_CH(NUM_CH), .PAGE_W(PAGE_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ch(req_ch),
    .req_to_dev(req_to_dev), .req_len(req_len),
    .en_i(en), .todev_i(todev), .cnt_i(cnt), .laddr_i(laddr),
    .base_i(base), .lim_ent_i(lim_ent),
    .ev_ch(ev_ch), .ev_start(ev_start), .ev_reject(ev_reject),
    .ev_done(ev_done), .ev_len(ev_len), .busy(busy),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data)
  );

  p_busy_blocks_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !mem_valid && !din_ready && !dout_valid);
endmodule

// File: tb/test_sgdma_engine.sv
module test_sgdma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_ch = '0;
  logic        req_to_dev = 1'b0;
  logic [31:0] req_len = '0;
  logic        busy;
  logic        mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        din_valid, din_ready;
  logic [31:0] din_data;
  logic        dout_valid, dout_ready;
  logic [31:0] dout_data;
  logic [3:0]  chan_err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic stall = 1'b0;

  logic [31:0] mem [0:4095];
  logic [31:0] rd_addrs [0:63];
  int rd_n = 0;
  int wr_n = 0;
  logic [31:0] dq [0:63];
  int dq_n = 0;
  int din_cnt = 0;

  always #10 clk = ~clk;

  sgdma_engine i_sgdma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_ch(req_ch),
    .req_to_dev(req_to_dev), .req_len(req_len), .busy(busy),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
    .chan_err(chan_err)
  );

  assign mem_ready  = stall ? (cyc % 3 == 0) : 1'b1;
  assign dout_ready = stall ? (cyc % 2 == 1) : 1'b1;
  assign din_valid  = stall ? (cyc % 2 == 0) : 1'b1;
  assign din_data   = 32'hD000_0000 + 32'(din_cnt);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_n <= wr_n + 1;
      end else begin
        mem_rdata  <= mem[mem_addr[13:2]];
        mem_rvalid <= 1'b1;
        if (rd_n < 64) rd_addrs[rd_n] <= mem_addr;
        rd_n <= rd_n + 1;
      end
    end
    if (dout_valid && dout_ready) begin
      if (dq_n < 64) dq[dq_n] <= dout_data;
      dq_n <= dq_n + 1;
    end
    if (din_valid && din_ready) din_cnt <= din_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic setup_ch(input int ch, input logic [31:0] fl, input logic [31:0] ct, input logic [31:0] ad);
    wreg(10'h100 + 10'(ch * 32), fl);
    wreg(10'h108 + 10'(ch * 32), ct);
    wreg(10'h110 + 10'(ch * 32), ad);
  endtask

  task automatic request(input int ch, input logic dir, input logic [31:0] len, output logic saw_busy);
    @(negedge clk);
    req_valid = 1'b1; req_ch = 2'(ch); req_to_dev = dir; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    saw_busy = busy && !req_ready;
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rreg(10'h100, v); check("R1 flags ch0", v, 32'h0);
    rreg(10'h148, v); check("R1 count ch2", v, 32'h0);
    rreg(10'h170, v); check("R1 addr ch3", v, 32'h0);
    rreg(10'h008, v); check("R1 base", v, 32'h0);
    rreg(10'h00C, v); check("R1 limit", v, 32'h0);
    check("R1 busy/err", {27'b0, busy, chan_err}, 32'h0);
  endtask

  task automatic t_reject;
    logic [31:0] v;
    logic b;
    int r0, w0;
    setup_ch(1, 32'h0, 32'h20, 32'h0);
    r0 = rd_n; w0 = wr_n;
    request(1, 1'b1, 32'd8, b);
    rreg(10'h120, v); check("R4 disabled sets bit9", v, 32'h200);
    rreg(10'h128, v); check("R4 count unchanged", v, 32'h20);
    check("R4 err bit1", 32'(chan_err), 32'h2);
    check("R4 no memory traffic", 32'(rd_n - r0 + wr_n - w0), 32'h0);
    setup_ch(2, 32'h1, 32'h8, 32'h2000);
    request(2, 1'b1, 32'd8, b);
    rreg(10'h140, v); check("R4 direction mismatch", v, 32'h201);
    check("R4 err bits", 32'(chan_err), 32'h6);
    wreg(10'h010, 32'h2);
    rreg(10'h010, v); check("R2 w1c error source", v, 32'h4);
  endtask

  task automatic t_m2d_split;
    logic [31:0] v;
    logic b;
    int r0, q0;
    setup_ch(0, 32'h3, 32'h40, 32'h0FF8);
    stall = 1'b1;
    r0 = rd_n; q0 = dq_n;
    request(0, 1'b1, 32'd16, b);
    stall = 1'b0;
    check("R12 busy while walking", 32'(b), 32'h1);
    check("R9 beat count", 32'(dq_n - q0), 32'd4);
    check("R9 word0", dq[q0],     32'hA500_0BFE);
    check("R9 word1", dq[q0 + 1], 32'hA500_0BFF);
    check("R7 word2 next page", dq[q0 + 2], 32'hA500_0C00);
    check("R9 word3", dq[q0 + 3], 32'hA500_0C01);
    check("R6 first fetch addr", rd_addrs[r0], 32'h0000_0100);
    check("R7 second fetch addr", rd_addrs[r0 + 3], 32'h0000_0108);
    rreg(10'h100, v); check("R5 done flag", v, 32'h103);
    rreg(10'h108, v); check("R5 count reduced", v, 32'h30);
  endtask

  task automatic t_d2m_clamp;
    logic [31:0] v;
    logic b;
    int w0, d0;
    setup_ch(2, 32'h201, 32'h8, 32'h2000);
    w0 = wr_n; d0 = din_cnt;
    request(2, 1'b0, 32'd16, b);
    check("R5 clamped writes", 32'(wr_n - w0), 32'd2);
    check("R10 word0 stored", mem[12'h400], 32'hD000_0000 + 32'(d0));
    check("R10 word1 stored", mem[12'h401], 32'hD000_0001 + 32'(d0));
    rreg(10'h140, v); check("R3 start clears bit9, R5 sets bit8", v, 32'h101);
    rreg(10'h148, v); check("R5 count to zero", v, 32'h0);
  endtask

  task automatic t_limit;
    logic [31:0] v;
    logic b;
    int w0, d0;
    wreg(10'h00C, 32'h8);
    setup_ch(3, 32'h1, 32'h20, 32'h0FF8);
    stall = 1'b1;
    w0 = wr_n; d0 = din_cnt;
    request(3, 1'b0, 32'd16, b);
    stall = 1'b0;
    check("R8 stops at limit", 32'(wr_n - w0), 32'd2);
    check("R10 first page data", mem[12'hBFE], 32'hD000_0000 + 32'(d0));
    rreg(10'h168, v); check("R8 count charged", v, 32'h10);
    rreg(10'h160, v); check("R8 done flag", v, 32'h101);
    wreg(10'h00C, 32'h40);
  endtask

  task automatic t_bit31;
    logic [31:0] v;
    logic b;
    int r0, q0;
    wreg(10'h008, 32'h8000_0100);
    setup_ch(0, 32'h3, 32'h30, 32'h1004);
    r0 = rd_n; q0 = dq_n;
    request(0, 1'b1, 32'd4, b);
    check("R6 bit31 forced low", rd_addrs[r0], 32'h0000_0108);
    check("R6 frame plus offset", dq[q0], 32'hA500_0C01);
    rreg(10'h108, v); check("R5 count after one word", v, 32'h2C);
    wreg(10'h008, 32'h100);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    logic b;
    int r0, w0;
    setup_ch(1, 32'h3, 32'h0, 32'h0);
    r0 = rd_n; w0 = wr_n;
    request(1, 1'b1, 32'd8, b);
    check("R5 zero length no traffic", 32'(rd_n - r0 + wr_n - w0), 32'h0);
    rreg(10'h120, v); check("R5 zero length done", v, 32'h103);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'hA500_0000 + 32'(i);
    mem[12'h040] = 32'h0000_2000;
    mem[12'h042] = 32'h0000_3000;
    mem[12'h044] = 32'h0000_1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    wreg(10'h008, 32'h100);
    wreg(10'h00C, 32'h40);
    t_reject;
    t_m2d_split;
    t_d2m_clamp;
    t_limit;
    t_bit31;
    t_zero;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule